// File: doc/BRIEF.md
# Two-direction latch/register bus transceiver

The block moves an 18-bit word between an A side and a B side, one storage path per direction. A path can pass data straight through, hold a stored word, or take a new word on a falling edge of its own strobe. A latch select chooses pass-through. A strobe-enable input, active low, qualifies the strobe. A drive-enable input, active low, makes that path's outputs drive or float. All bits of a direction share that direction's four controls. Output is never inverted.

The three-state function is given as a split data vector plus a per-bit drive-enable vector for each side, so the block fits inside a larger design. An outer pad ring can fold these onto bidirectional pins. The block runs on a system clock, and the direction strobes are sampled on it. A falling strobe is one that reads high at one system clock edge and low at the next. An asynchronous active-low reset clears both stored words and forces both sides to float.

Top module: `bidir_xcvr`

## Requirements
- R1: With latch select high and drive enabled, the output of that direction equals its input in the same cycle, with no clock needed.
- R2: With latch select low and the strobe at a steady level across two system clock edges, the stored word and the output do not change.
- R3: With latch select low and strobe-enable low, a strobe seen high at one system clock edge and low at the next loads the input present at the second edge. The output shows that word from then on.
- R4: With strobe-enable high, a falling strobe is ignored and the output keeps its previous word.
- R5: With drive-enable high, that side's drive-enable vector is all zeros and its data vector reads zero, whatever the other controls are.
- R6: The B-to-A path has the same behaviour as the A-to-B path, using its own four controls. Activity on one path never changes the word stored in the other path.
- R7: Every output bit equals the input bit at the same position, so bit i of A reaches bit i of B. No bit is inverted.
- R8: While reset is low, both drive-enable vectors are zero. After reset, each stored word is zero.
- R9: While latch select is high, the stored word follows the input at every clock edge. When latch select goes low, the word taken at the last edge with latch select high is kept.
- R10: A rising strobe never loads data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_in_i | input | 18 | Data received on the A side |
| b_in_i | input | 18 | Data received on the B side |
| ab_oe_ni | input | 1 | A-to-B drive enable, active low |
| ab_le_i | input | 1 | A-to-B latch select, high for pass-through |
| ab_cp_i | input | 1 | A-to-B strobe, loads on falling edge |
| ab_ce_ni | input | 1 | A-to-B strobe enable, active low |
| ba_oe_ni | input | 1 | B-to-A drive enable, active low |
| ba_le_i | input | 1 | B-to-A latch select, high for pass-through |
| ba_cp_i | input | 1 | B-to-A strobe, loads on falling edge |
| ba_ce_ni | input | 1 | B-to-A strobe enable, active low |
| b_out_o | output | 18 | Data driven onto the B side |
| b_oe_o | output | 18 | Per-bit drive enable for the B side |
| a_out_o | output | 18 | Data driven onto the A side |
| a_oe_o | output | 18 | Per-bit drive enable for the A side |

## Verification
The assertions assume that the two drive enables are never active together outside reset. With both directions in pass-through, such a state would be a bus conflict and a loop through the pins. The stimulus therefore floats one side before it enables the other.

The assertions also assume that each control changes at most once per system clock. The stimulus meets this by changing every input on the falling system clock edge only. It holds the strobes low through reset, so no strobe edge crosses the reset release.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  parameter int unsigned XCVR_W = 18;
  localparam int unsigned NUM_DIR = 2;

  typedef enum logic {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } xcvr_dir_e;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic cp;
    logic ce_n;
  } xcvr_ctrl_t;
endpackage

// File: rtl/xcvr_edge_det.sv
`timescale 1ns/1ps
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cp_i,
  input  logic ce_ni,
  output logic cap_o
);
  logic cp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cp_q <= 1'b0;
    else         cp_q <= cp_i;
  end

  // qualified high-to-low strobe transition
  assign cap_o = cp_q & ~cp_i & ~ce_ni;
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store #(
  parameter int unsigned W = xcvr_pkg::XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_o <= '0;
    else if (le_i || cap_i) q_o <= d_i;
  end

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !le_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  xcvr_ctrl_t   ctrl_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o
);
  logic         cap;
  logic [W-1:0] q;
  logic [W-1:0] drv;
  logic         en;

  xcvr_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cp_i  (ctrl_i.cp),
    .ce_ni (ctrl_i.ce_n),
    .cap_o (cap)
  );

  xcvr_store #(.W(W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (ctrl_i.le),
    .cap_i (cap),
    .d_i   (d_i),
    .q_o   (q)
  );

  assign drv   = ctrl_i.le ? d_i : q;
  assign en    = ~ctrl_i.oe_n & rst_ni;
  assign out_o = en ? drv : '0;
  assign oe_o  = {W{en}};

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.le && $stable(ctrl_i.cp)) |=> $stable(q));

  a_r4_ce_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.le && ctrl_i.ce_n) |=> $stable(q));

  a_r9_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.le |=> (q == $past(d_i)));
endmodule

// File: rtl/bidir_xcvr.sv
`timescale 1ns/1ps
module bidir_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_in_i,
  input  logic [W-1:0] b_in_i,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_cp_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_cp_i,
  input  logic         ba_ce_ni,
  output logic [W-1:0] b_out_o,
  output logic [W-1:0] b_oe_o,
  output logic [W-1:0] a_out_o,
  output logic [W-1:0] a_oe_o
);
  xcvr_ctrl_t [NUM_DIR-1:0]   ctrl;
  logic [NUM_DIR-1:0][W-1:0]  src;
  logic [NUM_DIR-1:0][W-1:0]  dst;
  logic [NUM_DIR-1:0][W-1:0]  dst_oe;

  assign ctrl[DIR_AB] = '{oe_n: ab_oe_ni, le: ab_le_i, cp: ab_cp_i, ce_n: ab_ce_ni};
  assign ctrl[DIR_BA] = '{oe_n: ba_oe_ni, le: ba_le_i, cp: ba_cp_i, ce_n: ba_ce_ni};
  assign src[DIR_AB]  = a_in_i;
  assign src[DIR_BA]  = b_in_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_lane #(.W(W)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ctrl_i(ctrl[d]),
      .d_i   (src[d]),
      .out_o (dst[d]),
      .oe_o  (dst_oe[d])
    );
  end

  assign b_out_o = dst[DIR_AB];
  assign b_oe_o  = dst_oe[DIR_AB];
  assign a_out_o = dst[DIR_BA];
  assign a_oe_o  = dst_oe[DIR_BA];

  a_r6_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ab_oe_ni && !ba_oe_ni));

  a_r5_float_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_ni |-> (b_oe_o == '0 && b_out_o == '0));

  a_r5_float_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> (a_oe_o == '0 && a_out_o == '0));
endmodule

// File: tb/bidir_xcvr_bench.sv
`timescale 1ns/1ps
module bidir_xcvr_bench;
  import xcvr_pkg::*;
  localparam int W     = 18;
  localparam int CLK_P = 10;

  typedef struct {
    logic [W-1:0] eb;
    logic         ebe;
    logic [W-1:0] ea;
    logic         eae;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  xcvr_ctrl_t ab = '{oe_n: 1'b1, le: 1'b0, cp: 1'b0, ce_n: 1'b1};
  xcvr_ctrl_t ba = '{oe_n: 1'b1, le: 1'b0, cp: 1'b0, ce_n: 1'b1};
  logic [W-1:0] b_out, b_oe, a_out, a_oe;

  int   n_run = 0, n_fail = 0;
  logic done = 1'b0;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  bidir_xcvr u_bidir_xcvr (
    .clk_i(clk), .rst_ni(rst_ni), .a_in_i(a_in), .b_in_i(b_in),
    .ab_oe_ni(ab.oe_n), .ab_le_i(ab.le), .ab_cp_i(ab.cp), .ab_ce_ni(ab.ce_n),
    .ba_oe_ni(ba.oe_n), .ba_le_i(ba.le), .ba_cp_i(ba.cp), .ba_ce_ni(ba.ce_n),
    .b_out_o(b_out), .b_oe_o(b_oe), .a_out_o(a_out), .a_oe_o(a_oe)
  );

  function automatic xcvr_ctrl_t mk(input logic oe_n, le, cp, ce_n);
    return '{oe_n: oe_n, le: le, cp: cp, ce_n: ce_n};
  endfunction

  task automatic cyc(input xcvr_ctrl_t c_ab, input xcvr_ctrl_t c_ba,
                     input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [W-1:0] eb, input logic ebe,
                     input logic [W-1:0] ea, input logic eae,
                     input string tag);
    exp_t e;
    @(negedge clk);
    ab = c_ab; ba = c_ba; a_in = a; b_in = b;
    e.eb = eb; e.ebe = ebe; e.ea = ea; e.eae = eae; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one expectation per cycle, sampled a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (b_out !== e.eb || b_oe !== {W{e.ebe}} ||
            a_out !== e.ea || a_oe !== {W{e.eae}}) begin
          n_fail++;
          $display("FAIL %s: b=%h/%h a=%h/%h expected b=%h/%h a=%h/%h",
                   e.tag, b_out, b_oe, a_out, a_oe,
                   e.eb, {W{e.ebe}}, e.ea, {W{e.eae}});
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    n_run++;
    if (b_oe !== '0 || a_oe !== '0) begin
      n_fail++;
      $display("FAIL %s: b_oe=%h a_oe=%h expected 0/0", tag, b_oe, a_oe);
    end
  endtask

  initial begin
    #(CLK_P*50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    xcvr_ctrl_t ba_off, ab_off;
    ba_off = mk(1'b1, 1'b0, 1'b0, 1'b1);
    ab_off = mk(1'b1, 1'b0, 1'b0, 1'b0);
    ab = mk(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("R8 outputs float in reset");
    rst_ni = 1'b1;

    cyc(mk(0,0,0,0), ba_off, 18'h2AAAA, '0, 18'h00000, 1, '0, 0, "R8 stored word zero");
    cyc(mk(0,1,0,0), ba_off, 18'h15555, '0, 18'h15555, 1, '0, 0, "R1 pass-through");
    cyc(mk(0,1,0,0), ba_off, 18'h3F00F, '0, 18'h3F00F, 1, '0, 0, "R7 bit order");
    cyc(mk(0,0,0,0), ba_off, 18'h3F00F, '0, 18'h3F00F, 1, '0, 0, "R9 latch select falls");
    cyc(mk(0,0,0,0), ba_off, 18'h00FF0, '0, 18'h3F00F, 1, '0, 0, "R9 word kept");
    cyc(mk(0,0,1,0), ba_off, 18'h12345, '0, 18'h3F00F, 1, '0, 0, "R10 rising strobe");
    cyc(mk(0,0,0,0), ba_off, 18'h0ABCD, '0, 18'h0ABCD, 1, '0, 0, "R3 falling strobe load");
    cyc(mk(0,0,0,0), ba_off, 18'h11111, '0, 18'h0ABCD, 1, '0, 0, "R2 strobe low hold");
    cyc(mk(0,0,1,0), ba_off, 18'h22222, '0, 18'h0ABCD, 1, '0, 0, "R2 strobe high hold");
    cyc(mk(0,0,0,1), ba_off, 18'h33333, '0, 18'h0ABCD, 1, '0, 0, "R4 strobe blocked");
    cyc(mk(0,0,1,0), ba_off, 18'h33333, '0, 18'h0ABCD, 1, '0, 0, "R10 rising strobe again");
    cyc(mk(0,0,0,0), ba_off, 18'h3FFFF, '0, 18'h3FFFF, 1, '0, 0, "R3 R7 all ones load");
    cyc(mk(1,1,0,0), ba_off, 18'h15555, '0, 18'h00000, 0, '0, 0, "R5 drive disabled");
    cyc(mk(0,0,0,0), ab_off == ab_off ? ba_off : ba_off, 18'h00000, '0, 18'h15555, 1, '0, 0,
        "R9 word taken while floating");
    cyc(ab_off, mk(0,1,0,0), 18'h3C3C3, 18'h2468A, '0, 0, 18'h2468A, 1, "R6 reverse pass-through");
    cyc(ab_off, mk(0,0,1,0), 18'h3C3C3, 18'h13579, '0, 0, 18'h2468A, 1, "R6 reverse hold");
    cyc(ab_off, mk(0,0,0,0), 18'h3C3C3, 18'h0F0F0, '0, 0, 18'h0F0F0, 1, "R6 reverse strobe load");
    cyc(mk(0,0,0,0), ba_off, 18'h3C3C3, 18'h0F0F0, 18'h15555, 1, '0, 0, "R6 forward word untouched");

    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_reset("R8 outputs float on mid-run reset");
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(mk(0,0,0,0), ba_off, 18'h3C3C3, '0, 18'h00000, 1, '0, 0, "R8 word cleared");

    repeat (2) @(posedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule